// File: doc/BRIEF.md
# Redial Number Store and Command Parser

This block holds the numbers a telephone redialer can dial again. One buffer records the number being dialed by hand. Nine repertory slots, numbered 1 to 9, hold numbers the user has saved. Every buffer has room for 18 symbols and keeps its own length count. The block receives decoded key codes, each marked by a one-cycle strobe, together with a key-held level and the hookswitch state. From these keys it parses the program, memory, redial and flash command sequences.

When the user asks for a stored number, the block sends that number's symbols one at a time to a downstream signaling sequencer over a valid/ready handshake. A stored flash goes out as a pause symbol. The sequencer turns it into a delay and does not produce a hook-flash break. While a key is held, replay is suspended. Any change of hook state aborts the command or replay in progress. While a programming sequence is open, the block raises a flag.

Top module: `redial_mem_ctrl`

## Requirements
- R1: Key codes are 0-9 for digits, 10 for star (pulse-to-tone switch), 11 for hash, 12 for flash, 13 for redial, 14 for memory and 15 for program. Codes 0-12 are storable symbols. There are nine repertory slots addressed by key codes 1-9, plus one redial buffer. Each buffer holds up to 18 symbols.
- R2: While off-hook and idle, each symbol key is appended to the redial buffer. The 19th and later symbols wrap around to position 0 and overwrite the oldest positions. The buffer length never exceeds 18, and replay reads the positions in order from position 0.
- R3: After a flash, the next non-flash symbol starts a new number, and the redial buffer then holds only that symbol. A flash that follows another flash is appended. A change of hook state also makes the next non-flash symbol start a new number.
- R4: The redial key, pressed off-hook, replays the redial buffer. A star replays as code 10 and a flash as pause code 12. Replay leaves the buffer unchanged. An empty buffer produces no output.
- R5: The sequence program, symbols, memory, location stores the collected symbols into that slot. Symbols beyond the 18th are dropped. The sequence works on-hook and off-hook. prog_mode_o is high from the program key until the sequence ends, and no symbol is offered while it is high.
- R6: The sequence program, memory, location with no symbols in between copies the redial buffer into the slot.
- R7: The sequence memory, location, given off-hook, replays that slot. On-hook, the memory, redial and symbol keys neither produce output nor change the redial buffer.
- R8: After a memory key, any code other than 1-9 ends the command without writing or replaying. In the symbol phase of programming, a redial or program key ends the command.
- R9: A symbol advances only when sym_valid_o and sym_ready_i are both high. While the block waits for ready, sym_o stays stable and sym_valid_o stays high.
- R10: While key_held_i is high, sym_valid_o is low. When the key is released, replay resumes at the same symbol.
- R11: Key strobes that arrive during a replay are ignored.
- R12: A change of off_hook_i drops sym_valid_o and prog_mode_o by the following cycle and cancels any pending write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| key_code_i | input | 4 | Decoded key code |
| key_stb_i | input | 1 | One-cycle strobe for key_code_i |
| key_held_i | input | 1 | High while any key is physically down |
| off_hook_i | input | 1 | 1 = off-hook, 0 = on-hook |
| sym_ready_i | input | 1 | Sequencer accepts the offered symbol |
| sym_o | output | 4 | Replayed symbol (0 when not valid) |
| sym_valid_o | output | 1 | sym_o is offered |
| prog_mode_o | output | 1 | A programming sequence is open |

## Verification
The bench targets the following corner cases, and what a faulty design would show in each:

- **Wrap past 18 symbols.** A design with an off-by-one write pointer would replay a shifted or 19-entry number.
- **New number after a flash.** A design that mishandles the new-number flag would either keep the old digits or drop consecutive flashes.
- **Save with an empty program body.** A design that always commits the collected symbols would store an empty slot instead of the redial buffer.
- **Bad location after a memory key.** A faulty design would corrupt a slot or start a replay.
- **Held key, random ready, keys during replay and hook changes.** A design that advances on valid alone, keeps offering symbols through a held key, or stores keys mid-replay would return a replay stream different from the one the bench predicts.

// File: rtl/redial_pkg.sv
package redial_pkg;
  localparam int unsigned NUM_LEN   = 18;
  localparam int unsigned NUM_SLOTS = 9;
  localparam int unsigned SYM_W     = 4;

  localparam logic [3:0] K_STAR  = 4'd10;
  localparam logic [3:0] K_HASH  = 4'd11;
  localparam logic [3:0] K_FLASH = 4'd12;
  localparam logic [3:0] K_LND   = 4'd13;
  localparam logic [3:0] K_MEM   = 4'd14;
  localparam logic [3:0] K_PROG  = 4'd15;

  typedef enum logic [1:0] {
    C_IDLE = 2'd0,
    C_PDIG = 2'd1,
    C_PLOC = 2'd2,
    C_MLOC = 2'd3
  } cmd_st_e;
endpackage

// File: rtl/redial_cmd_fsm.sv
module redial_cmd_fsm
  import redial_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = redial_pkg::NUM_SLOTS,
  localparam int unsigned SRC_W = $clog2(NUM_SLOTS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [3:0]       key_code_i,
  input  logic             key_stb_i,
  input  logic             off_hook_i,
  input  logic             rp_busy_i,
  output logic             lnd_wr_o,
  output logic             lnd_new_o,
  output logic             stg_clr_o,
  output logic             stg_wr_o,
  output logic             commit_o,
  output logic [SRC_W-1:0] loc_o,
  output logic             rp_start_o,
  output logic [SRC_W-1:0] rp_src_o,
  output logic             prog_mode_o,
  output logic             hook_chg_o
);
  cmd_st_e st_q, st_d;
  logic    hook_q;
  logic    new_num_q, new_num_d;
  logic    acc, is_sym, is_loc, is_flash;

  assign hook_chg_o = off_hook_i ^ hook_q;
  assign acc        = key_stb_i && !rp_busy_i && !hook_chg_o;
  assign is_flash   = (key_code_i == K_FLASH);
  assign is_sym     = (key_code_i <= K_FLASH);
  assign is_loc     = (key_code_i != 4'd0) && (32'(key_code_i) <= NUM_SLOTS);
  assign loc_o      = SRC_W'(key_code_i);
  assign prog_mode_o = (st_q == C_PDIG) || (st_q == C_PLOC);

  always_comb begin
    st_d       = st_q;
    new_num_d  = new_num_q;
    lnd_wr_o   = 1'b0;
    lnd_new_o  = 1'b0;
    stg_clr_o  = 1'b0;
    stg_wr_o   = 1'b0;
    commit_o   = 1'b0;
    rp_start_o = 1'b0;
    rp_src_o   = '0;
    if (acc) begin
      unique case (st_q)
        C_IDLE: begin
          if (key_code_i == K_PROG) begin
            st_d      = C_PDIG;
            stg_clr_o = 1'b1;
          end else if (off_hook_i) begin
            if (key_code_i == K_MEM) begin
              st_d = C_MLOC;
            end else if (key_code_i == K_LND) begin
              rp_start_o = 1'b1;
            end else begin
              // flash appends; first non-flash after flash/hook starts anew
              lnd_wr_o  = 1'b1;
              lnd_new_o = new_num_q && !is_flash;
              new_num_d = is_flash;
            end
          end
        end
        C_PDIG: begin
          if (is_sym)                    stg_wr_o = 1'b1;
          else if (key_code_i == K_MEM)  st_d = C_PLOC;
          else                           st_d = C_IDLE;
        end
        C_PLOC: begin
          commit_o = is_loc;
          st_d     = C_IDLE;
        end
        C_MLOC: begin
          rp_start_o = is_loc;
          rp_src_o   = loc_o;
          st_d       = C_IDLE;
        end
        default: st_d = C_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= C_IDLE;
      hook_q    <= 1'b0;
      new_num_q <= 1'b1;
    end else begin
      hook_q <= off_hook_i;
      if (hook_chg_o) begin
        st_q      <= C_IDLE;
        new_num_q <= 1'b1;
      end else begin
        st_q      <= st_d;
        new_num_q <= new_num_d;
      end
    end
  end
endmodule

// File: rtl/redial_store.sv
module redial_store #(
  parameter int unsigned NUM_LEN   = redial_pkg::NUM_LEN,
  parameter int unsigned NUM_SLOTS = redial_pkg::NUM_SLOTS,
  parameter int unsigned SYM_W     = redial_pkg::SYM_W,
  localparam int unsigned LEN_W = $clog2(NUM_LEN + 1),
  localparam int unsigned IDX_W = $clog2(NUM_LEN),
  localparam int unsigned SRC_W = $clog2(NUM_SLOTS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SYM_W-1:0] wr_sym_i,
  input  logic             lnd_wr_i,
  input  logic             lnd_new_i,
  input  logic             stg_clr_i,
  input  logic             stg_wr_i,
  input  logic             commit_i,
  input  logic [SRC_W-1:0] commit_loc_i,
  input  logic [SRC_W-1:0] rd_src_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [SYM_W-1:0] rd_sym_o,
  output logic [LEN_W-1:0] rd_len_o,
  output logic [LEN_W-1:0] lnd_len_o
);
  typedef logic [NUM_LEN-1:0][SYM_W-1:0] num_t;

  num_t             lnd_q, stg_q;
  logic [LEN_W-1:0] lnd_len_q, stg_len_q;
  logic [IDX_W-1:0] lnd_wp_q;
  num_t             src_num;
  logic [LEN_W-1:0] src_len;
  num_t             slot_rd     [NUM_SLOTS];
  logic [LEN_W-1:0] slot_len_rd [NUM_SLOTS];

  assign lnd_len_o = lnd_len_q;
  // an empty program body saves the redial buffer
  assign src_num = (stg_len_q == '0) ? lnd_q : stg_q;
  assign src_len = (stg_len_q == '0) ? lnd_len_q : stg_len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lnd_q     <= '0;
      lnd_len_q <= '0;
      lnd_wp_q  <= '0;
    end else if (lnd_wr_i) begin
      if (lnd_new_i) begin
        lnd_q[0]  <= wr_sym_i;
        lnd_len_q <= LEN_W'(1);
        lnd_wp_q  <= IDX_W'(1);
      end else begin
        lnd_q[lnd_wp_q] <= wr_sym_i;
        lnd_wp_q  <= (lnd_wp_q == IDX_W'(NUM_LEN - 1)) ? '0 : lnd_wp_q + IDX_W'(1);
        lnd_len_q <= (lnd_len_q == LEN_W'(NUM_LEN)) ? lnd_len_q : lnd_len_q + LEN_W'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q     <= '0;
      stg_len_q <= '0;
    end else if (stg_clr_i) begin
      stg_len_q <= '0;
    end else if (stg_wr_i && (stg_len_q != LEN_W'(NUM_LEN))) begin
      stg_q[stg_len_q[IDX_W-1:0]] <= wr_sym_i;
      stg_len_q <= stg_len_q + LEN_W'(1);
    end
  end

  for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
    num_t             data_q;
    logic [LEN_W-1:0] len_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        data_q <= '0;
        len_q  <= '0;
      end else if (commit_i && (commit_loc_i == SRC_W'(k + 1))) begin
        data_q <= src_num;
        len_q  <= src_len;
      end
    end
    assign slot_rd[k]     = data_q;
    assign slot_len_rd[k] = len_q;
  end

  always_comb begin
    rd_sym_o = lnd_q[rd_idx_i];
    rd_len_o = lnd_len_q;
    for (int k = 0; k < NUM_SLOTS; k++) begin
      if (rd_src_i == SRC_W'(k + 1)) begin
        rd_sym_o = slot_rd[k][rd_idx_i];
        rd_len_o = slot_len_rd[k];
      end
    end
  end
endmodule

// File: rtl/redial_replay.sv
module redial_replay #(
  parameter int unsigned NUM_LEN   = redial_pkg::NUM_LEN,
  parameter int unsigned NUM_SLOTS = redial_pkg::NUM_SLOTS,
  parameter int unsigned SYM_W     = redial_pkg::SYM_W,
  localparam int unsigned LEN_W = $clog2(NUM_LEN + 1),
  localparam int unsigned IDX_W = $clog2(NUM_LEN),
  localparam int unsigned SRC_W = $clog2(NUM_SLOTS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [SRC_W-1:0] start_src_i,
  input  logic             abort_i,
  input  logic             held_i,
  input  logic             ready_i,
  input  logic [LEN_W-1:0] rd_len_i,
  input  logic [SYM_W-1:0] rd_sym_i,
  output logic [SRC_W-1:0] rd_src_o,
  output logic [IDX_W-1:0] rd_idx_o,
  output logic             busy_o,
  output logic             valid_o,
  output logic [SYM_W-1:0] sym_o
);
  logic             busy_q;
  logic [SRC_W-1:0] src_q;
  logic [IDX_W-1:0] ptr_q;
  logic [LEN_W-1:0] len_q;
  logic             fire, last;

  assign rd_src_o = start_i ? start_src_i : src_q;
  assign rd_idx_o = ptr_q;
  assign busy_o   = busy_q;
  assign valid_o  = busy_q && !held_i;
  assign sym_o    = valid_o ? rd_sym_i : '0;
  assign fire     = valid_o && ready_i;
  assign last     = (LEN_W'(ptr_q) + LEN_W'(1)) == len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      src_q  <= '0;
      ptr_q  <= '0;
      len_q  <= '0;
    end else if (abort_i) begin
      busy_q <= 1'b0;
    end else if (start_i) begin
      src_q  <= start_src_i;
      ptr_q  <= '0;
      len_q  <= rd_len_i;
      busy_q <= (rd_len_i != '0);
    end else if (fire) begin
      if (last) busy_q <= 1'b0;
      else      ptr_q  <= ptr_q + IDX_W'(1);
    end
  end
endmodule

// File: rtl/redial_mem_ctrl.sv
module redial_mem_ctrl #(
  parameter int unsigned NUM_LEN   = redial_pkg::NUM_LEN,
  parameter int unsigned NUM_SLOTS = redial_pkg::NUM_SLOTS,
  localparam int unsigned SYM_W = redial_pkg::SYM_W,
  localparam int unsigned LEN_W = $clog2(NUM_LEN + 1),
  localparam int unsigned IDX_W = $clog2(NUM_LEN),
  localparam int unsigned SRC_W = $clog2(NUM_SLOTS + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [3:0] key_code_i,
  input  logic       key_stb_i,
  input  logic       key_held_i,
  input  logic       off_hook_i,
  input  logic       sym_ready_i,
  output logic [3:0] sym_o,
  output logic       sym_valid_o,
  output logic       prog_mode_o
);
  logic             lnd_wr, lnd_new, stg_clr, stg_wr, commit;
  logic [SRC_W-1:0] loc, rp_src, rd_src;
  logic             rp_start, rp_busy, hook_chg;
  logic [IDX_W-1:0] rd_idx;
  logic [SYM_W-1:0] rd_sym;
  logic [LEN_W-1:0] rd_len, lnd_len;

  redial_cmd_fsm #(.NUM_SLOTS(NUM_SLOTS)) u_fsm (
    .clk_i, .rst_ni, .key_code_i, .key_stb_i, .off_hook_i,
    .rp_busy_i  (rp_busy),
    .lnd_wr_o   (lnd_wr),
    .lnd_new_o  (lnd_new),
    .stg_clr_o  (stg_clr),
    .stg_wr_o   (stg_wr),
    .commit_o   (commit),
    .loc_o      (loc),
    .rp_start_o (rp_start),
    .rp_src_o   (rp_src),
    .prog_mode_o,
    .hook_chg_o (hook_chg)
  );

  redial_store #(.NUM_LEN(NUM_LEN), .NUM_SLOTS(NUM_SLOTS), .SYM_W(SYM_W)) u_store (
    .clk_i, .rst_ni,
    .wr_sym_i     (key_code_i),
    .lnd_wr_i     (lnd_wr),
    .lnd_new_i    (lnd_new),
    .stg_clr_i    (stg_clr),
    .stg_wr_i     (stg_wr),
    .commit_i     (commit),
    .commit_loc_i (loc),
    .rd_src_i     (rd_src),
    .rd_idx_i     (rd_idx),
    .rd_sym_o     (rd_sym),
    .rd_len_o     (rd_len),
    .lnd_len_o    (lnd_len)
  );

  redial_replay #(.NUM_LEN(NUM_LEN), .NUM_SLOTS(NUM_SLOTS), .SYM_W(SYM_W)) u_replay (
    .clk_i, .rst_ni,
    .start_i     (rp_start),
    .start_src_i (rp_src),
    .abort_i     (hook_chg),
    .held_i      (key_held_i),
    .ready_i     (sym_ready_i),
    .rd_len_i    (rd_len),
    .rd_sym_i    (rd_sym),
    .rd_src_o    (rd_src),
    .rd_idx_o    (rd_idx),
    .busy_o      (rp_busy),
    .valid_o     (sym_valid_o),
    .sym_o       (sym_o)
  );
endmodule

// File: rtl/redial_mem_ctrl_chk.sv
module redial_mem_ctrl_chk #(
  parameter int unsigned NUM_LEN = 18,
  localparam int unsigned LEN_W = $clog2(NUM_LEN + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             key_held_i,
  input logic             off_hook_i,
  input logic             sym_ready_i,
  input logic [3:0]       sym_o,
  input logic             sym_valid_o,
  input logic             prog_mode_o,
  input logic             hook_chg,
  input logic [LEN_W-1:0] lnd_len
);
  AST_LEN_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(lnd_len) <= NUM_LEN); // R2
  AST_PROG_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_mode_o |-> !sym_valid_o); // R5
  AST_OFFHOOK_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sym_valid_o |-> (off_hook_i || hook_chg)); // R7
  AST_WAIT_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sym_valid_o && !sym_ready_i && !hook_chg) |=> (key_held_i || (sym_valid_o && $stable(sym_o)))); // R9
  AST_HELD_PAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_held_i |-> !sym_valid_o); // R10
  AST_HOOK_ABORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hook_chg |=> (!sym_valid_o && !prog_mode_o)); // R12
endmodule

bind redial_mem_ctrl redial_mem_ctrl_chk #(.NUM_LEN(NUM_LEN)) u_chk (
  .clk_i, .rst_ni, .key_held_i, .off_hook_i, .sym_ready_i,
  .sym_o, .sym_valid_o, .prog_mode_o,
  .hook_chg (hook_chg),
  .lnd_len  (lnd_len)
);

// File: tb/sim_redial_mem_ctrl.sv
module sim_redial_mem_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int LEN = 18;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] key_code = '0;
  logic       key_stb = 1'b0, key_held = 1'b0, off_hook = 1'b0, sym_ready = 1'b0;
  logic [3:0] sym;
  logic       sym_valid, prog_mode;

  int checks = 0, fails = 0;

  logic [3:0] m_lnd [LEN];
  int         m_len = 0, m_wp = 0;
  bit         m_new = 1'b1;
  logic [3:0] m_slot [9][LEN];
  int         m_slen [9];
  logic [3:0] exp_s [LEN];
  int         exp_n;

  always #(CLK_PERIOD/2) clk = ~clk;

  redial_mem_ctrl u0 (
    .clk_i(clk), .rst_ni, .key_code_i(key_code), .key_stb_i(key_stb),
    .key_held_i(key_held), .off_hook_i(off_hook), .sym_ready_i(sym_ready),
    .sym_o(sym), .sym_valid_o(sym_valid), .prog_mode_o(prog_mode)
  );

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int next_wp(int wp);
    return (wp + 1) % LEN;
  endfunction

  task automatic press(logic [3:0] c);
    @(negedge clk);
    key_code = c;
    key_stb  = 1'b1;
    @(negedge clk);
    key_stb  = 1'b0;
  endtask

  // model of manual entry per R2/R3
  task automatic dial(logic [3:0] c);
    press(c);
    if (c != 4'd12 && m_new) begin
      m_lnd[0] = c; m_len = 1; m_wp = 1; m_new = 1'b0;
    end else begin
      m_lnd[m_wp] = c; m_wp = next_wp(m_wp);
      if (m_len < LEN) m_len++;
      if (c == 4'd12) m_new = 1'b1;
    end
  endtask

  task automatic set_hook(logic v);
    @(negedge clk);
    off_hook = v;
    @(negedge clk);
    m_new = 1'b1;
  endtask

  task automatic exp_lnd();
    exp_n = m_len;
    for (int i = 0; i < LEN; i++) exp_s[i] = m_lnd[i];
  endtask

  task automatic exp_slot(int k);
    exp_n = m_slen[k-1];
    for (int i = 0; i < LEN; i++) exp_s[i] = m_slot[k-1][i];
  endtask

  task automatic collect(string req);
    int  got = 0, guard = 0, bad_i = -1, act = 0, extra = 0;
    while (got < exp_n && guard < 2000) begin
      @(negedge clk);
      guard++;
      sym_ready = 1'($urandom_range(0, 1));
      if (sym_valid && sym_ready) begin
        if (sym !== exp_s[got] && bad_i < 0) begin bad_i = got; act = int'(sym); end
        got++;
      end
    end
    chk(bad_i < 0, req, "replay symbol", act, (bad_i < 0) ? 0 : int'(exp_s[bad_i]));
    chk(got == exp_n, req, "replay count", got, exp_n);
    sym_ready = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (sym_valid) extra++;
    end
    sym_ready = 1'b0;
    chk(extra == 0, req, "valid after last symbol", extra, 0);
  endtask

  task automatic quiet(string req, int n);
    int seen = 0;
    sym_ready = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (sym_valid) seen++;
    end
    sym_ready = 1'b0;
    chk(seen == 0, req, "unexpected valid", seen, 0);
  endtask

  task automatic program_slot(int k, int n);
    logic [3:0] c;
    int         cnt = 0;
    press(4'd15);
    chk(prog_mode == 1'b1, "R5", "prog_mode after program key", int'(prog_mode), 1);
    for (int i = 0; i < n; i++) begin
      c = 4'($urandom_range(0, 12));
      press(c);
      if (cnt < LEN) begin m_slot[k-1][cnt] = c; cnt++; end
    end
    press(4'd14);
    press(4'(k));
    chk(prog_mode == 1'b0, "R5", "prog_mode after location", int'(prog_mode), 0);
    if (n == 0) begin
      for (int i = 0; i < LEN; i++) m_slot[k-1][i] = m_lnd[i];
      m_slen[k-1] = m_len;
    end else begin
      m_slen[k-1] = cnt;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    chk(1'b0, "R1", "watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    for (int k = 0; k < 9; k++) m_slen[k] = 0;
    for (int i = 0; i < LEN; i++) m_lnd[i] = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(sym_valid == 1'b0, "R9", "reset valid", int'(sym_valid), 0);
    chk(prog_mode == 1'b0, "R5", "reset prog_mode", int'(prog_mode), 0);

    // R4: empty redial buffer replays nothing
    set_hook(1'b1);
    press(4'd13);
    quiet("R4", 6);

    // R3/R4: flash handling, star and hash stored
    dial(4'd1); dial(4'd10); dial(4'd11); dial(4'd12); dial(4'd12);
    press(4'd13); exp_lnd(); collect("R3");
    dial(4'd7);
    press(4'd13); exp_lnd(); collect("R3");
    chk(m_len == 1, "R3", "model new number length", m_len, 1);
    dial(4'd12); dial(4'd12);
    press(4'd13); exp_lnd(); collect("R4");

    // R2: wrap past 18 symbols
    for (int i = 0; i < 23; i++) dial(4'(i % 10));
    press(4'd13); exp_lnd(); collect("R2");

    // R6: save redial buffer into slot 9 with empty body
    program_slot(9, 0);
    press(4'd14); press(4'd9); exp_slot(9); collect("R6");

    // R5/R7: program slots with random bodies, replay them (R1 all slots)
    for (int r = 0; r < 9; r++) begin
      int k = r + 1;
      int n = $urandom_range(1, 20);
      program_slot(k, n);
      press(4'd14); press(4'(k)); exp_slot(k); collect("R7");
    end

    // R11: keys during replay ignored, buffer unchanged
    press(4'd13);
    press(4'd5); press(4'd6); press(4'd14);
    exp_lnd(); collect("R11");
    press(4'd13); exp_lnd(); collect("R11");

    // R9/R10: stall and held key
    press(4'd13);
    exp_lnd();
    @(negedge clk);
    chk(sym_valid == 1'b1 && sym == exp_s[0], "R9", "offered first symbol", int'(sym), int'(exp_s[0]));
    @(negedge clk);
    chk(sym_valid == 1'b1 && sym == exp_s[0], "R9", "held while not ready", int'(sym), int'(exp_s[0]));
    key_held = 1'b1;
    sym_ready = 1'b1;
    begin
      int seen = 0;
      for (int i = 0; i < 5; i++) begin
        @(negedge clk);
        if (sym_valid) seen++;
      end
      chk(seen == 0, "R10", "valid while key held", seen, 0);
    end
    key_held = 1'b0;
    sym_ready = 1'b0;
    collect("R10");

    // R8: bad location and stray keys abort
    press(4'd15); press(4'd4); press(4'd4); press(4'd14); press(4'd0);
    chk(prog_mode == 1'b0, "R8", "prog_mode after bad location", int'(prog_mode), 0);
    press(4'd14); press(4'd3); exp_slot(3); collect("R8");
    press(4'd14); press(4'd13);
    quiet("R8", 6);
    press(4'd15); press(4'd2); press(4'd13);
    chk(prog_mode == 1'b0, "R8", "prog aborted by redial key", int'(prog_mode), 0);
    press(4'd14); press(4'd2); exp_slot(2); collect("R8");

    // R12: hook change aborts replay and programming
    press(4'd13);
    @(negedge clk);
    chk(sym_valid == 1'b1, "R12", "replay running before hook change", int'(sym_valid), 1);
    set_hook(1'b0);
    chk(sym_valid == 1'b0, "R12", "valid after hook change", int'(sym_valid), 0);
    press(4'd15); press(4'd8);
    set_hook(1'b1);
    chk(prog_mode == 1'b0, "R12", "prog_mode after hook change", int'(prog_mode), 0);
    press(4'd14); press(4'd1); exp_slot(1); collect("R12");

    // R7/R5: on-hook keys inert, on-hook programming works
    set_hook(1'b0);
    press(4'd14); press(4'd5);
    quiet("R7", 6);
    press(4'd13); press(4'd3); press(4'd4);
    quiet("R7", 6);
    program_slot(5, 4);
    set_hook(1'b1);
    press(4'd13); exp_lnd(); collect("R7");
    press(4'd14); press(4'd5); exp_slot(5); collect("R5");

    // R2/R3: random manual numbers after a hook cycle
    for (int r = 0; r < 4; r++) begin
      int n = $urandom_range(1, 25);
      for (int i = 0; i < n; i++) dial(4'($urandom_range(0, 12)));
      press(4'd13); exp_lnd(); collect("R2");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule